// File: doc/BRIEF.md
# Staggered-Phase Fine-Resolution Event Delay

This block delays single event strobes by a fixed, long interval. The delay is built from several identical shift-register tracks, not from one long chain. The fast clock runs at NUM_TRACKS times the shift rate. A phase counter visits each track in turn, so each track shifts once per shift period, and the shift instants are spread evenly across that period. Every incoming event is first synchronised to the fast clock. A retriggerable stretcher then widens it to one full shift period, and the stretched pulse is presented to all tracks at the same time. Because each track samples the pulse at a different phase, the AND of the track outputs is much narrower than a shift period. The timing uncertainty therefore falls to one fast-clock cycle, while each track needs only TRACK_BITS stages.

An output shaper turns the AND signal into uniform one-cycle pulses. It emits a pulse on the first cycle of every AND run. When two events arrive close together, their windows merge into one AND run of three or more cycles. In that case the shaper also emits a pulse on the last cycle of the run, so both events come out with their original spacing.

The event input and the delayed output are single-bit strobes that carry no payload. There is no valid/ready pairing and no back-pressure: an event that arrives is always accepted, and the output pulse cannot be stalled.

Top module: `stagger_fine_delay`

## Requirements
- R1: While `rst` is high, `pulse_o` is low. A reset asserted while events are in flight discards them, and no pulse follows later.
- R2: An event produces exactly one output pulse, with latency L = TRACK_BITS*NUM_TRACKS + 4 fast-clock edges. Latency is counted from the edge that first samples `evt_i` high to the cycle in which `pulse_o` is high.
- R3: The latency in R2 is the same for all NUM_TRACKS alignments of the event relative to the phase counter.
- R4: Only a low-to-high transition of `evt_i` is an event. Holding `evt_i` high for several cycles, including longer than a shift period, yields a single pulse.
- R5: Two events whose rising samples are s ≥ 2 cycles apart yield two pulses, at L and L+s. This holds both when their stretched windows merge and when they do not.
- R6: Every output pulse lasts exactly one fast-clock cycle, and pulses never occur in back-to-back cycles.
- R7: Track i (0-based) changes its output only in the cycle right after a cycle in which the phase counter equals i. The counter runs 0 to NUM_TRACKS-1 and then wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, NUM_TRACKS times the shift rate |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 1 | Asynchronous event strobe; rising transitions are events |
| pulse_o | output | 1 | Delayed event, one fast-clock cycle wide |

## Verification
A phase counter that skips or repeats a value would leave some track sampling the stretched pulse twice or never. That shows at `pulse_o` as a pulse that is missing or shifted for some input alignments, within one delay interval L. A stretcher whose length is wrong, or that fails to reload, changes the width of the AND run. For close pairs this appears as a missing second pulse or a second pulse at the wrong spacing, and it is visible on the first pair at L+s. A fault in the shaper appears as a doubled, widened or absent pulse on the very first event.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  // Minimum of one bit for any counter or index.
  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Length of a run of high cycles on the AND signal, saturating.
  typedef enum logic [1:0] {
    RUN_NONE  = 2'd0,
    RUN_ONE   = 2'd1,
    RUN_TWO   = 2'd2,
    RUN_LONG  = 2'd3
  } run_len_e;
endpackage

// File: rtl/sfd_front.sv
module sfd_front
  import sfd_pkg::*;
#(
  parameter int unsigned STRETCH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  output logic stretch_o
);
  localparam int unsigned CW = bits_for(STRETCH + 1);

  logic [2:0]    sync_q;
  logic          rise;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], evt_i};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  // Retriggerable: every new edge reloads a full shift period.
  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (rise)         cnt_q <= CW'(STRETCH);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign stretch_o = (cnt_q != '0);

  // R4
  stretch_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stretch_o) |-> $past(rise));

  // R4
  stretch_load_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> stretch_o);
endmodule

// File: rtl/sfd_track.sv
module sfd_track #(
  parameter int unsigned DEPTH = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] sr_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (shift_en) sr_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = sr_q[DEPTH-1];

  // R7
  track_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> $past(shift_en));
endmodule

// File: rtl/sfd_outnet.sv
module sfd_outnet
  import sfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic and_i,
  output logic pulse_o
);
  run_len_e run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= RUN_NONE;
    else if (!and_i) run_q <= RUN_NONE;
    else begin
      unique case (run_q)
        RUN_NONE: run_q <= RUN_ONE;
        RUN_ONE:  run_q <= RUN_TWO;
        default:  run_q <= RUN_LONG;
      endcase
    end
  end

  // Pulse on the first cycle of a run, and on the last cycle of a run
  // of three or more (two merged events).
  always_ff @(posedge clk) begin
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= (run_q == RUN_ONE) | ((run_q == RUN_LONG) & ~and_i);
  end

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/stagger_fine_delay.sv
module stagger_fine_delay
  import sfd_pkg::*;
#(
  parameter int unsigned NUM_TRACKS = 5,
  parameter int unsigned TRACK_BITS = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  output logic pulse_o
);
  localparam int unsigned PW = bits_for(NUM_TRACKS);

  logic [PW-1:0]         phase_q;
  logic                  stretched;
  logic [NUM_TRACKS-1:0] taps;
  logic                  and_sig;

  always_ff @(posedge clk) begin
    if (rst)                               phase_q <= '0;
    else if (phase_q == PW'(NUM_TRACKS-1)) phase_q <= '0;
    else                                   phase_q <= phase_q + 1'b1;
  end

  sfd_front #(.STRETCH(NUM_TRACKS)) u_front (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .stretch_o (stretched)
  );

  for (genvar i = 0; i < NUM_TRACKS; i++) begin : g_trk
    logic sh;
    assign sh = (phase_q == PW'(i));
    sfd_track #(.DEPTH(TRACK_BITS)) u_track (
      .clk      (clk),
      .rst      (rst),
      .shift_en (sh),
      .din      (stretched),
      .dout     (taps[i])
    );
  end

  assign and_sig = &taps;

  sfd_outnet u_out (
    .clk     (clk),
    .rst     (rst),
    .and_i   (and_sig),
    .pulse_o (pulse_o)
  );

  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(and_sig, 2));
endmodule

// File: tb/tb_stagger_fine_delay.sv
module tb_stagger_fine_delay;
  localparam int K = 4;
  localparam int M = 3;
  localparam int L = K * M + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_i = 1'b0;
  logic pulse_o;

  int vecs = 0;
  int bad  = 0;

  stagger_fine_delay #(.NUM_TRACKS(K), .TRACK_BITS(M)) dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .pulse_o(pulse_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string req, input int n);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: pulse_o=%0b expected %0b", req, n, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(pulse_o, 1'b0, "R2 idle", i);
    end
  endtask

  // First event held for 'hold' cycles; optional second one-cycle event at s.
  task automatic run_case(input int s, input int hold, input string req);
    evt_i = 1'b1;
    for (int n = 0; n <= L + s + K + 6; n++) begin
      @(negedge clk);
      chk(pulse_o, (n == L) || (s > 0 && n == L + s), req, n);
      if (n == hold - 1) evt_i = 1'b0;
      if (s > 0 && n == s - 1) evt_i = 1'b1;
      if (s > 0 && n == s) evt_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    // R1: output quiet during reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(pulse_o, 1'b0, "R1", i);
    end
    rst = 1'b0;
    idle(K + 3);

    // R2/R6: single event, one-cycle pulse at L
    run_case(0, 1, "R2/R6");

    // R3/R7: every alignment against the phase counter
    for (int d = 0; d < K; d++) begin
      idle(d + 1);
      run_case(0, 1, "R3/R7");
    end

    // R4: level held high counts once
    idle(3);
    run_case(0, 3, "R4");
    idle(2);
    run_case(0, K + 2, "R4");

    // R5: pairs, merged and separate windows
    for (int s = 2; s <= 2 * K + 2; s++) begin
      idle(1 + (s % K));
      run_case(s, 1, "R5");
    end

    // R1: reset while an event is in flight discards it
    evt_i = 1'b1;
    @(negedge clk);
    evt_i = 1'b0;
    repeat (L / 2) @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(pulse_o, 1'b0, "R1", i);
    end
    rst = 1'b0;
    for (int i = 0; i < L + K + 6; i++) begin
      @(negedge clk);
      chk(pulse_o, 1'b0, "R1", i);
    end

    // R2: normal operation after the flush
    run_case(0, 1, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule